// File: doc/BRIEF.md
# Four-Wire Synchronous Serial Controller

This block is a register-programmed synchronous serial port with four lines: serial clock, a transmit data line, a receive data line and chip select. It acts either as master, generating the serial clock from the system clock through a selectable divider and framing each transfer with chip select, or as slave, shifting on an external clock while an external chip select is low. Software sets clock polarity, clock phase, bit order, frame length (1 to 16 bits) and the role through a small register bus. It moves data through a transmit word and a receive word, and watches four status flags that can raise one interrupt line.

The mode and format words are locked while either enable is set, so the frame shape can never change under a running transfer. Received data survives a receive disable. The overrun flag needs a read of the flag followed by a write of zero to clear. An optional bidirectional setting makes the transmit line also serve as the receive input. Pad open-drain control and pin multiplexing sit outside. The block only gives drive values and output enables.

Top module: `quad_sync_serial`

## Requirements
- R1: After reset the status word (address 3; bit0 receive-full, bit1 transmit-empty, bit2 transmit-end, bit3 overrun) reads 0x06. Chip select output is high, serial clock output is low, the transmit line is not driven and irq is low.
- R2: Writes to the mode word (address 1) and the format word (address 2) are ignored while transmit enable (control word, address 0, bit0) or receive enable (control bit1) is 1.
- R3: In master role (mode bit3=1) with transmit enabled, writing the transmit word (address 4) pulls chip select low and emits 2N serial clock edges starting from the idle level given by mode bit1. Data is sampled on the 1st, 3rd, ... edges when mode bit0=0 and on the 2nd, 4th, ... edges when mode bit0=1. Afterwards chip select is high again and the clock rests at its idle level.
- R4: Format bits 3:0 hold N-1, so a frame carries 1 to 16 bits. With mode bit2=0 bit N-1 goes out first; with mode bit2=1 bit 0 goes out first. The receive word (address 5) is right-aligned under the same order.
- R5: A frame that completes while receive-full is 1 sets overrun and is discarded; the held receive word is kept.
- R6: Overrun clears only on a status write with bit3=0 that follows a status read returning overrun=1. A zero write with no such read leaves it set.
- R7: With receive enable 0, completed frames are not stored, and receive-full, overrun and the receive word keep their values.
- R8: Writing the transmit word clears transmit-end. When a frame ends with no further word queued, transmit-empty and transmit-end both read 1. Reading the receive word clears receive-full.
- R9: Mode bits 6:4 = k give a serial clock half period of 2^k system cycles. Chip select rises one half period after the last clock edge.
- R10: With mode bit7=1 the block receives from the transmit line's input instead of the separate receive line.
- R11: In slave role (mode bit3=0) with format bits 5:4 = 01, the block shifts on the external clock while external chip select is low. It sends the transmit word and stores the received word. Format bit5=1 makes chip select an output in master role.
- R12: irq = ((receive-full or overrun) and control bit2) or (transmit-empty and control bit3) or (transmit-end and control bit4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on status and receive word) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | Serial clock from pad (slave) |
| sclk_o | output | 1 | Serial clock drive value |
| sclk_oe | output | 1 | Serial clock output enable |
| cs_i | input | 1 | Chip select from pad, active low |
| cs_o | output | 1 | Chip select drive value, active low |
| cs_oe | output | 1 | Chip select output enable |
| txln_i | input | 1 | Transmit line read back from pad |
| txln_o | output | 1 | Transmit line drive value |
| txln_oe | output | 1 | Transmit line output enable |
| rxln_i | input | 1 | Receive line from pad |

## Verification
The assertions check, on every cycle, that the mode and format words stay still while an enable is set and that overrun never drops without a status write. They also check that the receive word moves only when a frame completes, that a transmit word write always leaves transmit-empty low, and that chip select is high whenever the engine is idle. Only the bench scenarios can show the shape of the frame: the edge at which each bit is sampled, the bit order, the length, the clock half period and the chip select tail. The same holds for the loopback contents, the bidirectional input choice and the slave role on an external clock. A pin monitor decodes every master frame from the clock, chip select and transmit line, and compares it against the words queued by the driver.

// File: rtl/qss_pkg.sv
`timescale 1ns/1ps
package qss_pkg;
    parameter int LENW = 4;                 // frame length code width
    parameter int DIVW = 3;                 // clock divider select width
    parameter int AW   = 3;                 // register address width
    localparam int DW    = 1 << LENW;       // widest frame / data word
    localparam int CNTW  = $clog2(2 * DW) + 1;
    localparam int HALFW = 1 << DIVW;       // holds 2^(2^DIVW - 1)

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_MODE = 3'd1;
    localparam logic [AW-1:0] A_FMT  = 3'd2;
    localparam logic [AW-1:0] A_STAT = 3'd3;
    localparam logic [AW-1:0] A_TXD  = 3'd4;
    localparam logic [AW-1:0] A_RXD  = 3'd5;

    typedef struct packed {
        logic tend_ie;
        logic txe_ie;
        logic rxf_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic            bidir;
        logic [DIVW-1:0] div;
        logic            master;
        logic            lsb;
        logic            cpol;
        logic            cpha;
    } mode_t;

    typedef struct packed {
        logic [1:0]      cs_sel;
        logic [LENW-1:0] len;   // bits per frame minus one
    } fmt_t;

    typedef enum logic [1:0] {S_IDLE, S_LEAD, S_RUN, S_TAIL} eng_st_t;

    // Word position of the i-th bit on the wire.
    function automatic logic [LENW-1:0] wire_pos(logic [LENW:0] i, logic [LENW-1:0] len,
                                                 logic lsb);
        logic [LENW:0] p;
        p = lsb ? i : ({1'b0, len} - i);
        return p[LENW-1:0];
    endfunction

    function automatic logic pick_bit(logic [DW-1:0] w, logic [LENW:0] i,
                                      logic [LENW-1:0] len, logic lsb);
        if (i > {1'b0, len}) return 1'b0;
        return w[wire_pos(i, len, lsb)];
    endfunction
endpackage

// File: rtl/qss_regs.sv
`timescale 1ns/1ps
module qss_regs
    import qss_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          loaded,
    input  logic          done,
    input  logic [DW-1:0] rx_word,
    output ctrl_t         ctrl_o,
    output mode_t         mode_o,
    output fmt_t          fmt_o,
    output logic [DW-1:0] tx_word,
    output logic          start,
    output logic          irq
);
    ctrl_t         ctrl_q;
    mode_t         mode_q;
    fmt_t          fmt_q;
    logic [DW-1:0] txd_q, rxd_q;
    logic          rxf_q, txe_q, tend_q, ovr_q, ovr_seen_q;

    logic enabled, wr_ctrl, wr_mode, wr_fmt, wr_stat, wr_txd, rd_stat, rd_rxd;
    assign enabled = ctrl_q.tx_en | ctrl_q.rx_en;
    assign wr_ctrl = sel & wr & (addr == A_CTRL);
    assign wr_mode = sel & wr & (addr == A_MODE);
    assign wr_fmt  = sel & wr & (addr == A_FMT);
    assign wr_stat = sel & wr & (addr == A_STAT);
    assign wr_txd  = sel & wr & (addr == A_TXD);
    assign rd_stat = sel & rd & (addr == A_STAT);
    assign rd_rxd  = sel & rd & (addr == A_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            mode_q     <= '0;
            fmt_q      <= '{cs_sel: 2'b00, len: LENW'(7)};
            txd_q      <= '0;
            rxd_q      <= '0;
            rxf_q      <= 1'b0;
            txe_q      <= 1'b1;
            tend_q     <= 1'b1;
            ovr_q      <= 1'b0;
            ovr_seen_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[4:0]);
            if (wr_mode && !enabled) mode_q <= mode_t'(wdata[7:0]);
            if (wr_fmt && !enabled) fmt_q <= fmt_t'(wdata[5:0]);
            if (loaded) txe_q <= 1'b1;
            if (wr_txd) begin
                txd_q  <= wdata;
                txe_q  <= 1'b0;
                tend_q <= 1'b0;
            end
            if (rd_rxd) rxf_q <= 1'b0;
            // overrun: read as one arms the clear, a zero write then clears
            if (rd_stat && ovr_q) ovr_seen_q <= 1'b1;
            if (wr_stat && !wdata[3] && ovr_seen_q) begin
                ovr_q      <= 1'b0;
                ovr_seen_q <= 1'b0;
            end
            if (done) begin
                if (txe_q && !wr_txd) tend_q <= 1'b1;
                if (ctrl_q.rx_en) begin
                    if (rxf_q && !rd_rxd) begin
                        ovr_q <= 1'b1;
                    end else begin
                        rxd_q <= rx_word;
                        rxf_q <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[4:0] = ctrl_q;
            A_MODE:  rdata[7:0] = mode_q;
            A_FMT:   rdata[5:0] = fmt_q;
            A_STAT:  rdata[3:0] = {ovr_q, tend_q, txe_q, rxf_q};
            A_TXD:   rdata      = txd_q;
            A_RXD:   rdata      = rxd_q;
            default: rdata      = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign mode_o  = mode_q;
    assign fmt_o   = fmt_q;
    assign tx_word = txd_q;
    assign start   = mode_q.master & ctrl_q.tx_en & ~txe_q & ~busy;
    assign irq     = ((rxf_q | ovr_q) & ctrl_q.rxf_ie) | (txe_q & ctrl_q.txe_ie) |
                     (tend_q & ctrl_q.tend_ie);

    a_r2_mode_locked: assert property (@(posedge clk) disable iff (rst)
        enabled |=> ($stable(mode_q) && $stable(fmt_q)));
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !wr_stat) |=> ovr_q);
    a_r7_rxd_held: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rxd_q));
    a_r8_txe_cleared: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> !txe_q);
endmodule

// File: rtl/qss_engine.sv
`timescale 1ns/1ps
module qss_engine
    import qss_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  fmt_t          fmt,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          start,
    input  logic [DW-1:0] tx_word,
    input  logic          sclk_i,
    input  logic          cs_i,
    input  logic          txln_i,
    input  logic          rxln_i,
    output logic          busy,
    output logic          loaded,
    output logic          done,
    output logic [DW-1:0] rx_word,
    output logic          sclk_o,
    output logic          sclk_oe,
    output logic          txln_o,
    output logic          txln_oe,
    output logic          cs_o,
    output logic          cs_oe
);
    eng_st_t          st;
    logic [HALFW-1:0] half_cnt;
    logic [CNTW-1:0]  edge_cnt;
    logic [LENW:0]    bitn;
    logic [DW-1:0]    sh_tx, sh_rx;
    logic             sclk_q, dout_q, cs_q, done_q, loaded_q;
    logic [2:0]       sck_sync;
    logic [1:0]       cs_sync;

    logic [HALFW-1:0] half_len;
    logic [CNTW-1:0]  last_edge;
    logic             tick, selected, ev, sample_ev, din;

    assign half_len  = HALFW'(1) << mode.div;
    assign tick      = (half_cnt == half_len - HALFW'(1));
    assign last_edge = CNTW'({1'b0, fmt.len, 1'b1});          // 2N - 1
    assign selected  = (fmt.cs_sel == 2'b01) ? ~cs_sync[1] : 1'b1;
    assign ev        = (st == S_RUN) &&
                       (mode.master ? tick : (sck_sync[1] ^ sck_sync[2]));
    assign sample_ev = ev && (edge_cnt[0] == mode.cpha);
    assign din       = mode.bidir ? txln_i : rxln_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            cs_sync  <= 2'b11;
        end else begin
            sck_sync <= {sck_sync[1:0], sclk_i};
            cs_sync  <= {cs_sync[0], cs_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            half_cnt <= '0;
            edge_cnt <= '0;
            bitn     <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            sclk_q   <= 1'b0;
            dout_q   <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b0;
            loaded_q <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            loaded_q <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    sclk_q   <= mode.cpol;
                    half_cnt <= '0;
                    edge_cnt <= '0;
                    bitn     <= '0;
                    if ((mode.master && start) ||
                        (!mode.master && (tx_en || rx_en) && selected)) begin
                        sh_tx    <= tx_word;
                        sh_rx    <= '0;
                        dout_q   <= pick_bit(tx_word, '0, fmt.len, mode.lsb);
                        loaded_q <= 1'b1;
                        if (mode.master) begin
                            cs_q <= 1'b0;
                            st   <= S_LEAD;
                        end else begin
                            st <= S_RUN;
                        end
                    end
                end
                S_LEAD: begin
                    half_cnt <= tick ? '0 : half_cnt + HALFW'(1);
                    if (tick) st <= S_RUN;
                end
                S_RUN: begin
                    half_cnt <= tick ? '0 : half_cnt + HALFW'(1);
                    if (ev) begin
                        edge_cnt <= edge_cnt + CNTW'(1);
                        sclk_q   <= ~sclk_q;
                        if (sample_ev) begin
                            sh_rx[wire_pos(bitn, fmt.len, mode.lsb)] <= din;
                            bitn <= bitn + 1'b1;
                        end else begin
                            dout_q <= pick_bit(sh_tx, bitn, fmt.len, mode.lsb);
                        end
                        if (edge_cnt == last_edge) begin
                            if (mode.master) begin
                                st <= S_TAIL;
                            end else begin
                                done_q <= 1'b1;
                                st     <= S_IDLE;
                            end
                        end
                    end
                    if (!mode.master && !selected) st <= S_IDLE;
                end
                S_TAIL: begin
                    half_cnt <= tick ? '0 : half_cnt + HALFW'(1);
                    if (tick) begin
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy    = (st != S_IDLE);
    assign loaded  = loaded_q;
    assign done    = done_q;
    assign rx_word = sh_rx;
    assign sclk_o  = sclk_q;
    assign sclk_oe = mode.master;
    assign txln_o  = dout_q;
    assign txln_oe = tx_en & (mode.master | (st == S_RUN));
    assign cs_o    = cs_q;
    assign cs_oe   = mode.master & fmt.cs_sel[1];

    a_r3_cs_idle: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> cs_q);
endmodule

// File: rtl/quad_sync_serial.sv
`timescale 1ns/1ps
module quad_sync_serial
    import qss_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          sclk_i,
    output logic          sclk_o,
    output logic          sclk_oe,
    input  logic          cs_i,
    output logic          cs_o,
    output logic          cs_oe,
    input  logic          txln_i,
    output logic          txln_o,
    output logic          txln_oe,
    input  logic          rxln_i
);
    ctrl_t         ctrl;
    mode_t         mode;
    fmt_t          fmt;
    logic [DW-1:0] tx_word, rx_word;
    logic          busy, loaded, done, start;

    qss_regs u_regs (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .busy(busy), .loaded(loaded), .done(done), .rx_word(rx_word),
        .ctrl_o(ctrl), .mode_o(mode), .fmt_o(fmt), .tx_word(tx_word),
        .start(start), .irq(irq)
    );

    qss_engine u_eng (
        .clk(clk), .rst(rst), .mode(mode), .fmt(fmt),
        .tx_en(ctrl.tx_en), .rx_en(ctrl.rx_en), .start(start), .tx_word(tx_word),
        .sclk_i(sclk_i), .cs_i(cs_i), .txln_i(txln_i), .rxln_i(rxln_i),
        .busy(busy), .loaded(loaded), .done(done), .rx_word(rx_word),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .txln_o(txln_o), .txln_oe(txln_oe),
        .cs_o(cs_o), .cs_oe(cs_oe)
    );
endmodule

// File: tb/quad_sync_serial_tb.sv
`timescale 1ns/1ps
module quad_sync_serial_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        irq, sclk_o, sclk_oe, cs_o, cs_oe, txln_o, txln_oe;
    logic        sclk_i = 0, cs_i = 1, ext_b = 0, loop_b = 1;
    logic        txln_i, rxln_i;

    assign txln_i = txln_oe ? txln_o : 1'b0;
    assign rxln_i = loop_b ? txln_o : ext_b;

    always #10 clk = ~clk;   // 50 MHz

    quad_sync_serial dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .cs_i(cs_i), .cs_o(cs_o), .cs_oe(cs_oe),
        .txln_i(txln_i), .txln_o(txln_o), .txln_oe(txln_oe), .rxln_i(rxln_i)
    );

    int n_chk = 0, n_fail = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard items
    typedef struct {
        int          n;
        logic [15:0] w;
        bit          cpha;
        bit          lsb;
    } frame_t;
    frame_t sb_q[$];
    frame_t cur;

    // pin monitor: decodes master frames and compares with queued items
    logic        prev_cs = 1, prev_sclk = 0, mon_on = 0;
    int          m_idx, m_n;
    logic [15:0] m_bits, m_word;
    int unsigned last_edge_cyc = 0, last_gap = 0, tail_gap = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 1; prev_sclk = sclk_o; mon_on = 0;
        end else begin
            if (mon_on && sclk_o !== prev_sclk) begin
                if (m_idx > 0) last_gap = cyc - last_edge_cyc;
                last_edge_cyc = cyc;
                if ((m_idx % 2) == int'(cur.cpha)) begin
                    m_bits = {m_bits[14:0], txln_o};
                    m_n++;
                end
                m_idx++;
            end
            if (cs_oe && prev_cs && !cs_o) begin
                mon_on = 1; m_idx = 0; m_n = 0; m_bits = 0;
                if (sb_q.size() == 0) begin
                    chk(0, "R3 unexpected frame", 0, 1);
                    cur = '{n: 0, w: 0, cpha: 0, lsb: 0};
                end else begin
                    cur = sb_q.pop_front();
                end
            end else if (mon_on && cs_o) begin
                mon_on = 0;
                tail_gap = cyc - last_edge_cyc;
                m_word = 0;
                for (int i = 0; i < m_n; i++)
                    if (cur.lsb) m_word[i] = m_bits[m_n-1-i];
                    else         m_word[i] = m_bits[i];
                chk(m_n == cur.n, "R3 bit count", m_n, cur.n);
                chk(m_idx == 2 * cur.n, "R3 clock edges", m_idx, 2 * cur.n);
                chk(m_word == cur.w, "R4 wire word", m_word, cur.w);
            end
            prev_cs = cs_oe ? cs_o : 1'b1;
            prev_sclk = sclk_o;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wait_frame();
        while (cs_o !== 1'b0) @(negedge clk);
        while (cs_o !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int n, input bit cpha, input bit lsb);
        sb_q.push_back('{n: n, w: w & 16'((32'h1 << n) - 1), cpha: cpha, lsb: lsb});
        wr(3'd4, w);
        wait_frame();
    endtask

    task automatic cfg(input logic [15:0] mode, input logic [15:0] fmt,
                       input logic [15:0] ctrl);
        wr(3'd0, 16'h0000);
        wr(3'd1, mode);
        wr(3'd2, fmt);
        wr(3'd0, ctrl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        summary();
    end

    logic [15:0] v, miso;

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        rd(3'd3, v);
        chk(v == 16'h0006, "R1 status", v, 16'h0006);
        chk(cs_o == 1'b1 && sclk_o == 1'b0, "R1 pins", {cs_o, sclk_o}, 2'b10);
        chk(txln_oe == 1'b0 && irq == 1'b0, "R1 idle", {txln_oe, irq}, 2'b00);

        // master, 8 bits, MSB first, mode 0, divider 1
        cfg(16'h0008, 16'h0027, 16'h0003);
        wr(3'd1, 16'h000C);
        rd(3'd1, v);
        chk(v == 16'h0008, "R2 mode locked", v, 16'h0008);
        wr(3'd2, 16'h0020);
        rd(3'd2, v);
        chk(v == 16'h0027, "R2 format locked", v, 16'h0027);

        send(16'h00A5, 8, 0, 0);
        rd(3'd3, v);
        chk(v == 16'h0007, "R8 status after frame", v, 16'h0007);
        rd(3'd5, v);
        chk(v == 16'h00A5, "R3 loopback word", v, 16'h00A5);
        rd(3'd3, v);
        chk(v == 16'h0006, "R8 rxf cleared by read", v, 16'h0006);
        chk(cs_o == 1'b1 && sclk_o == 1'b0, "R3 rest state", {cs_o, sclk_o}, 2'b10);

        // 12 bits, LSB first, cpol=1, cpha=1, half period 4
        cfg(16'h002F, 16'h002B, 16'h0003);
        @(negedge clk);
        chk(sclk_o == 1'b1, "R3 idle high", sclk_o, 1);
        send(16'h05C3, 12, 1, 1);
        chk(last_gap == 4, "R9 half period", last_gap, 4);
        chk(tail_gap == 4, "R9 cs tail", tail_gap, 4);
        rd(3'd5, v);
        chk(v == 16'h05C3, "R4 lsb 12 bit", v, 16'h05C3);

        // 16 bits and 1 bit
        cfg(16'h0008, 16'h002F, 16'h0003);
        send(16'hBEEF, 16, 0, 0);
        rd(3'd5, v);
        chk(v == 16'hBEEF, "R4 16 bit", v, 16'hBEEF);
        cfg(16'h0008, 16'h0020, 16'h0003);
        send(16'h0003, 1, 0, 0);
        rd(3'd5, v);
        chk(v == 16'h0001, "R4 1 bit", v, 16'h0001);

        // overrun
        cfg(16'h0008, 16'h0027, 16'h0003);
        send(16'h0011, 8, 0, 0);
        send(16'h0022, 8, 0, 0);
        wr(3'd3, 16'h0000);
        rd(3'd3, v);
        chk(v == 16'h000F, "R5 R6 overrun set, blind clear ignored", v, 16'h000F);
        wr(3'd3, 16'h0000);
        rd(3'd3, v);
        chk(v == 16'h0007, "R6 overrun cleared", v, 16'h0007);
        rd(3'd5, v);
        chk(v == 16'h0011, "R5 first word kept", v, 16'h0011);

        // receive disable keeps data
        send(16'h0033, 8, 0, 0);
        wr(3'd0, 16'h0001);
        wr(3'd4, 16'h0044);
        sb_q.push_back('{n: 8, w: 16'h0044, cpha: 0, lsb: 0});
        rd(3'd3, v);
        chk((v & 16'h0004) == 0, "R8 tend low mid frame", v, 0);
        wait_frame();
        rd(3'd3, v);
        chk(v == 16'h0007, "R7 flags held", v, 16'h0007);
        wr(3'd0, 16'h0005);
        @(negedge clk);
        chk(irq == 1'b1, "R12 rxf irq", irq, 1);
        rd(3'd5, v);
        chk(v == 16'h0033, "R7 word held", v, 16'h0033);
        chk(irq == 1'b0, "R12 irq drops", irq, 0);
        wr(3'd0, 16'h0009);
        @(negedge clk);
        chk(irq == 1'b1, "R12 txe irq", irq, 1);

        // bidirectional line
        loop_b = 0; ext_b = 0;
        cfg(16'h0088, 16'h0027, 16'h0003);
        send(16'h005A, 8, 0, 0);
        rd(3'd5, v);
        chk(v == 16'h005A, "R10 bidir receive", v, 16'h005A);

        // slave, external clock, chip select input
        cfg(16'h0000, 16'h0017, 16'h0003);
        wr(3'd4, 16'h00C3);
        miso = 0;
        cs_i = 0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            ext_b = 8'h96 >> i;
            repeat (8) @(negedge clk);
            sclk_i = 1;
            miso = {miso[14:0], txln_o};
            repeat (8) @(negedge clk);
            sclk_i = 0;
        end
        repeat (8) @(negedge clk);
        cs_i = 1;
        repeat (6) @(negedge clk);
        chk(miso == 16'h00C3, "R11 slave sends", miso, 16'h00C3);
        rd(3'd5, v);
        chk(v == 16'h0096, "R11 slave receives", v, 16'h0096);
        chk(sclk_oe == 1'b0 && cs_oe == 1'b0, "R11 slave pins", {sclk_oe, cs_oe}, 0);

        chk(sb_q.size() == 0, "R3 all frames seen", sb_q.size(), 0);
        summary();
    end
endmodule